// File: doc/BRIEF.md
# Channel Volume Envelope

This block produces the 4-bit loudness level of one tone or noise voice. A restart strobe captures a settings byte that carries a starting level, a direction and a step period, together with a separate shutdown option bit. From then on, a slow tick of about 64 Hz drives a period counter. Each time the counter completes its period, the level moves one step up or down. The level stops at 0 or at 15 and never wraps.

A channel-active flag is set by each restart. When the shutdown option was captured, the flag falls as soon as the envelope ends; without the option, the voice keeps its last level. A global sound-off input clears the flag at any time. While the flag is low, the level output reads zero. The settings byte and the option bit are sampled only at a restart, so software may rewrite them during a note without disturbing it.

Top module: `vol_envelope`

## Requirements
- R1: After reset, `vol_o` is 0 and `active_o` is 0.
- R2: A cycle with `kick_i` high and `snd_off_i` low restarts the envelope. On the next cycle, `active_o` is 1 and `vol_o` equals `cfg_i[7:4]`.
- R3: If the captured rate `cfg_i[2:0]` is 0, the level never changes and the channel is never shut down by the envelope, whatever the ticks and direction bit do.
- R4: For a captured rate n greater than 0, the level changes on the n-th accepted `tick_i` after the restart and then on every n-th accepted tick. Cycles without a tick change nothing.
- R5: When captured `cfg_i[3]` is 1, each step adds one and the level stops at 15. When it is 0, each step subtracts one and the level stops at 0.
- R6: The envelope ends at a step that either lands on the limit or finds the level already there. When captured `stay_i` is 1, `active_o` falls on that same edge. `vol_o` reads 0 whenever `active_o` is 0.
- R7: When captured `stay_i` is 0, the end of the envelope leaves `active_o` at 1 and `vol_o` at the limit value.
- R8: Changes to `cfg_i` or `stay_i` after a restart have no effect until the next restart.
- R9: `snd_off_i` high clears `active_o` on the next cycle and blocks a restart in the same cycle.
- R10: When `kick_i` and `tick_i` are both high in the same cycle, the restart wins and the tick is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_i | input | 8 | Settings: [7:4] starting level, [3] direction (1 = up), [2:0] step period in ticks |
| stay_i | input | 1 | Shutdown option: turn the channel off when the envelope ends |
| kick_i | input | 1 | Restart strobe, one cycle |
| tick_i | input | 1 | Envelope tick, one cycle per 64 Hz period |
| snd_off_i | input | 1 | Global sound-off |
| vol_o | output | 4 | Current level, 0 while inactive |
| active_o | output | 1 | Channel-active flag |

## Verification
A restart and a tick can fall in the same cycle. So can a restart and the step that would end the envelope, and a sound-off with either of them. The random stimulus raises all three strobes independently, so these collisions occur often, and directed cases also place a restart exactly on the tick that completes a period. A cycle-level reference in the bench applies the stated priority, and its expected level and flag are compared after every edge.

// File: rtl/vol_env_pkg.sv
package vol_env_pkg;
  parameter int VOL_W  = 4;
  parameter int RATE_W = 3;
  localparam int CFG_W = VOL_W + 1 + RATE_W;

  typedef struct packed {
    logic [VOL_W-1:0]  init;
    logic              up;
    logic [RATE_W-1:0] rate;
    logic              stay;
  } env_set_t;
endpackage

// File: rtl/env_latch.sv
module env_latch
  import vol_env_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CFG_W-1:0] cfg,
  input  logic             stay,
  output env_set_t         set_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      set_q <= '0;
    end else if (load) begin
      set_q.init <= cfg[CFG_W-1 -: VOL_W];
      set_q.up   <= cfg[RATE_W];
      set_q.rate <= cfg[RATE_W-1:0];
      set_q.stay <= stay;
    end
  end
endmodule

// File: rtl/env_timer.sv
module env_timer
  import vol_env_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [RATE_W-1:0] load_rate,
  input  logic [RATE_W-1:0] hold_rate,
  input  logic              run,
  output logic              step
);
  logic [RATE_W-1:0] cnt_q;
  localparam logic [RATE_W-1:0] ONE = RATE_W'(1);

  assign step = run && (cnt_q == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_rate;
    end else if (step) begin
      cnt_q <= hold_rate;
    end else if (run) begin
      cnt_q <= cnt_q - ONE;
    end
  end
endmodule

// File: rtl/env_level.sv
module env_level
  import vol_env_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             off,
  input  logic             load,
  input  logic [VOL_W-1:0] load_vol,
  input  logic             up,
  input  logic             stay,
  input  logic             step,
  output logic [VOL_W-1:0] vol_q,
  output logic             active_q,
  output logic             done_q
);
  localparam logic [VOL_W-1:0] TOP = '1;
  localparam logic [VOL_W-1:0] ONE = VOL_W'(1);

  logic [VOL_W-1:0] limit;
  logic [VOL_W-1:0] next_vol;
  logic             at_end;

  always_comb begin
    limit    = up ? TOP : '0;
    next_vol = (vol_q == limit) ? vol_q : (up ? vol_q + ONE : vol_q - ONE);
    at_end   = (next_vol == limit);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vol_q    <= '0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
    end else if (off) begin
      active_q <= 1'b0;
    end else if (load) begin
      vol_q    <= load_vol;
      active_q <= 1'b1;
      done_q   <= 1'b0;
    end else if (step) begin
      vol_q <= next_vol;
      if (at_end) begin
        done_q <= 1'b1;
        if (stay) active_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/vol_envelope.sv
module vol_envelope
  import vol_env_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             stay_i,
  input  logic             kick_i,
  input  logic             tick_i,
  input  logic             snd_off_i,
  output logic [VOL_W-1:0] vol_o,
  output logic             active_o
);
  env_set_t         set_q;
  logic             load;
  logic             run;
  logic             step;
  logic [VOL_W-1:0] vol_q;
  logic             active_q;
  logic             done_q;

  assign load = kick_i && !snd_off_i;
  assign run  = tick_i && !load && !snd_off_i && active_q && !done_q
                && (set_q.rate != '0);

  env_latch u_latch (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .cfg   (cfg_i),
    .stay  (stay_i),
    .set_q (set_q)
  );

  env_timer u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_rate (cfg_i[RATE_W-1:0]),
    .hold_rate (set_q.rate),
    .run       (run),
    .step      (step)
  );

  env_level u_level (
    .clk      (clk),
    .rst_n    (rst_n),
    .off      (snd_off_i),
    .load     (load),
    .load_vol (cfg_i[CFG_W-1 -: VOL_W]),
    .up       (set_q.up),
    .stay     (set_q.stay),
    .step     (step),
    .vol_q    (vol_q),
    .active_q (active_q),
    .done_q   (done_q)
  );

  assign vol_o    = active_q ? vol_q : '0;
  assign active_o = active_q;
endmodule

// File: rtl/env_chk.sv
module env_chk
  import vol_env_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [CFG_W-1:0] cfg_i,
  input logic             kick_i,
  input logic             tick_i,
  input logic             snd_off_i,
  input logic [VOL_W-1:0] vol_o,
  input logic             active_o
);
  // R2
  kick_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kick_i && !snd_off_i) |=> (active_o && vol_o == $past(cfg_i[CFG_W-1 -: VOL_W])));

  // R9
  off_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snd_off_i |=> !active_o);

  // R4
  no_tick_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!kick_i && !tick_i && !snd_off_i) |=> ($stable(vol_o) && $stable(active_o)));

  // R6
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active_o |-> (vol_o == '0));

  // R5
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!kick_i && !snd_off_i && active_o) |=>
      (!active_o || vol_o == $past(vol_o)
       || ($past(vol_o) != '1 && vol_o == $past(vol_o) + VOL_W'(1))
       || ($past(vol_o) != '0 && vol_o == $past(vol_o) - VOL_W'(1))));

  // R1
  never_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_o && !kick_i) |=> !active_o);
endmodule

bind vol_envelope env_chk u_env_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_i     (cfg_i),
  .kick_i    (kick_i),
  .tick_i    (tick_i),
  .snd_off_i (snd_off_i),
  .vol_o     (vol_o),
  .active_o  (active_o)
);

// File: tb/test_vol_envelope.sv
module test_vol_envelope;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cfg_i = '0;
  logic       stay_i = 1'b0;
  logic       kick_i = 1'b0;
  logic       tick_i = 1'b0;
  logic       snd_off_i = 1'b0;
  logic [3:0] vol_o;
  logic       active_o;

  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;

  // reference state
  logic [3:0] m_vol = '0, m_init = '0;
  logic       m_act = 1'b0, m_done = 1'b0, m_up = 1'b0, m_stay = 1'b0;
  logic [2:0] m_rate = '0, m_cnt = '0;

  always #5 clk = ~clk;

  vol_envelope i_vol_envelope (
    .clk(clk), .rst_n(rst_n), .cfg_i(cfg_i), .stay_i(stay_i),
    .kick_i(kick_i), .tick_i(tick_i), .snd_off_i(snd_off_i),
    .vol_o(vol_o), .active_o(active_o)
  );

  function automatic logic [3:0] step_of(logic [3:0] v, logic up);
    if (up) return (v == 4'hF) ? v : v + 4'd1;
    return (v == 4'h0) ? v : v - 4'd1;
  endfunction

  task automatic model_edge();
    logic [3:0] nv;
    if (!rst_n) begin
      m_vol = '0; m_act = 0; m_done = 0; m_up = 0; m_stay = 0; m_rate = '0; m_cnt = '0;
    end else if (snd_off_i) begin
      m_act = 0;
    end else if (kick_i) begin
      m_vol = cfg_i[7:4]; m_up = cfg_i[3]; m_rate = cfg_i[2:0]; m_stay = stay_i;
      m_cnt = cfg_i[2:0]; m_act = 1; m_done = 0;
    end else if (tick_i && m_act && !m_done && m_rate != 0) begin
      if (m_cnt == 3'd1) begin
        nv = step_of(m_vol, m_up);
        m_vol = nv;
        m_cnt = m_rate;
        if (nv == (m_up ? 4'hF : 4'h0)) begin
          m_done = 1;
          if (m_stay) m_act = 0;
        end
      end else begin
        m_cnt = m_cnt - 3'd1;
      end
    end
  endtask

  task automatic check(string req);
    logic [3:0] ev;
    ev = m_act ? m_vol : 4'h0;
    checks++;
    if (vol_o !== ev || active_o !== m_act) begin
      errors++;
      $display("FAIL %s vol=%0d active=%0d expected vol=%0d active=%0d",
               req, vol_o, active_o, ev, m_act);
    end
  endtask

  // one cycle: drive at negedge, reference at posedge, compare at next negedge
  task automatic cyc(logic k, logic t, logic o, string req);
    kick_i = k; tick_i = t; snd_off_i = o;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    kick_i = 0; tick_i = 0; snd_off_i = 0;
    check(req);
  endtask

  task automatic kick(logic [7:0] c, logic s, string req);
    cfg_i = c; stay_i = s;
    cyc(1, 0, 0, req);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(posedge clk); model_edge();
    @(negedge clk);
    check("R1");
    rst_n = 1;
    cyc(0, 1, 0, "R1");

    // R2 load, R3 rate zero holds
    kick(8'hA0, 1, "R2");
    for (int i = 0; i < 20; i++) cyc(0, 1, 0, "R3");
    // R4 up, rate 3; R8 change cfg mid-note
    kick(8'h5B, 0, "R2");
    cfg_i = 8'h01; stay_i = 1;
    for (int i = 0; i < 40; i++) cyc(0, (i % 2) == 0, 0, "R4 R5 R8");
    // R7 hold at 15 without shutdown
    for (int i = 0; i < 10; i++) cyc(0, 1, 0, "R7");
    // R5/R6 down rate 1 with stay
    kick(8'h31, 1, "R2");
    for (int i = 0; i < 6; i++) cyc(0, 1, 0, "R5 R6");
    // R6 already at limit: up from 15
    kick(8'hF9, 1, "R2");
    cyc(0, 1, 0, "R6");
    // R10 kick on completing tick
    kick(8'h82, 0, "R2");
    cyc(0, 1, 0, "R10");
    cfg_i = 8'h8A;
    cyc(1, 1, 0, "R10");
    cyc(0, 1, 0, "R10");
    cyc(0, 1, 0, "R10");
    // R9 off blocks kick
    cyc(1, 0, 1, "R9");
    cyc(0, 1, 0, "R9");

    // random
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 20000; i++) begin
      if (($urandom % 8) == 0) cfg_i = 8'($urandom);
      if (($urandom % 8) == 0) stay_i = 1'($urandom);
      cyc(($urandom % 24) == 0, ($urandom % 3) == 0, ($urandom % 200) == 0,
          "R4 R5 R6 R9 R10");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule